// File: doc/BRIEF.md
# Hop-Count Spoof Filter

This block inspects the header of each arriving IPv4 packet and decides whether the packet should be forwarded or dropped. Routers cannot forge the number of hops a packet has travelled. The block therefore guesses the sender's starting TTL, subtracts the received TTL, and compares the resulting hop distance with the distance previously recorded for that source address. A packet whose distance disagrees with the record is reported as spoofed. A packet that arrives with a TTL of zero is always dropped.

The records sit in a small direct-mapped table. The table is indexed by the low ten source-address bits and tagged with the remaining upper bits. A source with no usable record is passed. When learning is enabled, that source's current hop distance is written into the table. A host port can preload, overwrite or invalidate any entry. The upstream parser drives one header strobe per packet. A verdict strobe comes back a fixed three cycles later, and a new header may be presented on every cycle.

Top module: `hop_spoof_filter`

## Requirements
- R1: After reset no verdict is issued, and every table entry is invalid, so the first packet from any source is a miss.
- R2: For each cycle with `hdr_valid` high, exactly one verdict is issued with `verdict_valid` high exactly 3 cycles later, with one header accepted per cycle. While `verdict_valid` is low, `verdict_cause` and `verdict_drop` are 0.
- R3: The assumed starting TTL is the smallest of {30, 32, 60, 64, 128, 255} that is greater than or equal to the received TTL.
- R4: The hop distance is the assumed starting TTL minus the received TTL. It is held at 31 when the difference exceeds 31.
- R5: A header with TTL 0 yields `verdict_cause` = 3 and `verdict_drop` = 1, and it never writes the table.
- R6: When the indexed entry is valid and its tag equals source bits [31:10], a stored hop equal to the computed hop gives cause 0 with no drop. A different stored hop gives cause 2 with drop.
- R7: A miss (invalid entry or tag mismatch) gives cause 1 with no drop. If `learn_en` was high with that header, the entry at index source[9:0] becomes {valid, source[31:10], computed hop}.
- R8: A miss whose header came with `learn_en` low leaves the table unchanged.
- R9: A source that shares bits [9:0] with a recorded source but differs in bits [31:10] is treated as a miss.
- R10: A host write stores {`host_wr_vld`, `host_wr_tag`, `host_wr_hop`} at `host_wr_idx`, and writing valid 0 removes an entry. When a host write and a learning write fall in the same cycle, the host write is performed and the learning write is discarded.
- R11: A header sees the effect of every table write caused by earlier headers and earlier host writes, including a learning write from the header one cycle ahead of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header strobe, one per packet |
| hdr_src_addr | input | 32 | IPv4 source address of the packet |
| hdr_ttl | input | 8 | Received TTL of the packet |
| learn_en | input | 1 | Allow a miss from this header to record its source |
| host_wr_en | input | 1 | Host table write strobe |
| host_wr_idx | input | 10 | Table index for the host write |
| host_wr_vld | input | 1 | Valid bit to store (0 removes the entry) |
| host_wr_tag | input | 22 | Tag (source bits [31:10]) to store |
| host_wr_hop | input | 5 | Hop distance to store |
| verdict_valid | output | 1 | Verdict strobe, three cycles after the header |
| verdict_drop | output | 1 | 1 when the packet must be discarded |
| verdict_cause | output | 2 | 0 record match, 1 miss, 2 hop mismatch, 3 TTL zero |

## Verification
The bench preloads entries through the host port and then sends TTLs on both sides of each candidate boundary. It also sends TTLs far enough from 255 to exercise the hop saturation. A wrong boundary comparison or a wrapped subtraction turns an expected match into a mismatch. Pairs of headers from the same new source are sent on consecutive cycles. A table without write forwarding would report the second one as a miss. A host write is aimed at the exact cycle of a learning write, where the wrong priority leaves the learned hop in place. Further checks target TTL 0, learning switched off, and an alias that shares the index but not the tag: a design that writes on TTL 0, learns while disabled or ignores the tag turns a later miss into a hit or a mismatch.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    // Single point of configuration for the filter datapath.
    localparam int ADDR_W = 32;
    localparam int TTL_W  = 8;
    localparam int IDX_W  = 10;
    localparam int HOP_W  = 5;
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int N_CAND = 6;

    localparam logic [TTL_W-1:0] HOP_MAX = TTL_W'((1 << HOP_W) - 1);

    // Common starting TTLs, ascending.
    localparam logic [TTL_W-1:0] CAND_TTL [N_CAND] = '{
        8'd30, 8'd32, 8'd60, 8'd64, 8'd128, 8'd255
    };

    typedef enum logic [1:0] {
        CAUSE_HIT      = 2'd0,
        CAUSE_MISS     = 2'd1,
        CAUSE_HOP_BAD  = 2'd2,
        CAUSE_TTL_ZERO = 2'd3
    } cause_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [HOP_W-1:0] hop;
    } tbl_payload_t;

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [HOP_W-1:0] hop;
    } tbl_entry_t;

    typedef struct packed {
        logic             vld;
        logic             learn;
        logic             ttl_zero;
        logic [IDX_W-1:0] idx;
        logic [TAG_W-1:0] tag;
        logic [HOP_W-1:0] hop;
    } hdr_stage_t;

    // Smallest candidate not below the received TTL.
    function automatic logic [TTL_W-1:0] infer_initial_ttl(input logic [TTL_W-1:0] ttl);
        logic [TTL_W-1:0] pick;
        pick = CAND_TTL[N_CAND-1];
        for (int i = N_CAND - 1; i >= 0; i--) begin
            if (CAND_TTL[i] >= ttl) pick = CAND_TTL[i];
        end
        return pick;
    endfunction

endpackage

// File: rtl/hcf_hop_calc.sv
module hcf_hop_calc
    import hcf_pkg::*;
(
    input  logic [TTL_W-1:0] ttl,
    output logic [HOP_W-1:0] hop,
    output logic             ttl_zero
);

    logic [TTL_W-1:0] start_ttl;
    logic [TTL_W-1:0] distance;

    always_comb begin
        start_ttl = infer_initial_ttl(ttl);
        distance  = start_ttl - ttl;
        if (distance > HOP_MAX) hop = HOP_MAX[HOP_W-1:0];
        else                    hop = distance[HOP_W-1:0];
        ttl_zero  = (ttl == '0);
    end

endmodule

// File: rtl/hcf_table.sv
module hcf_table
    import hcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output tbl_entry_t       rd_entry,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  tbl_entry_t       wr_entry
);

    // Payload storage carries no reset; validity lives in a resettable vector.
    tbl_payload_t     data_mem [DEPTH];
    logic [DEPTH-1:0] vld_bits;

    tbl_payload_t     rd_q_data;
    logic             rd_q_vld;
    logic [IDX_W-1:0] rd_q_idx;

    // Copy of the write committed at the previous edge, for forwarding.
    logic             lw_valid;
    logic [IDX_W-1:0] lw_idx;
    tbl_entry_t       lw_entry;

    always_ff @(posedge clk) begin
        if (we) data_mem[wr_idx] <= tbl_payload_t'({wr_entry.tag, wr_entry.hop});
        rd_q_data <= data_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_bits <= '0;
            rd_q_vld <= 1'b0;
            rd_q_idx <= '0;
            lw_valid <= 1'b0;
            lw_idx   <= '0;
            lw_entry <= '0;
        end else begin
            if (we) vld_bits[wr_idx] <= wr_entry.vld;
            rd_q_vld <= vld_bits[rd_idx];
            rd_q_idx <= rd_idx;
            lw_valid <= we;
            lw_idx   <= wr_idx;
            lw_entry <= wr_entry;
        end
    end

    always_comb begin
        if (lw_valid && (lw_idx == rd_q_idx)) rd_entry = lw_entry;
        else rd_entry = tbl_entry_t'({rd_q_vld, rd_q_data.tag, rd_q_data.hop});
    end

endmodule

// File: rtl/hcf_judge.sv
module hcf_judge
    import hcf_pkg::*;
(
    input  hdr_stage_t stg,
    input  tbl_entry_t entry,
    output cause_e     cause,
    output logic       learn_we,
    output tbl_entry_t learn_entry
);

    logic hit;

    always_comb begin
        hit = entry.vld && (entry.tag == stg.tag);
        if (stg.ttl_zero)            cause = CAUSE_TTL_ZERO;
        else if (!hit)               cause = CAUSE_MISS;
        else if (entry.hop == stg.hop) cause = CAUSE_HIT;
        else                         cause = CAUSE_HOP_BAD;

        learn_we        = stg.vld && stg.learn && !stg.ttl_zero && !hit;
        learn_entry.vld = 1'b1;
        learn_entry.tag = stg.tag;
        learn_entry.hop = stg.hop;
    end

endmodule

// File: rtl/hop_spoof_filter.sv
module hop_spoof_filter
    import hcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_src_addr,
    input  logic [TTL_W-1:0]  hdr_ttl,
    input  logic              learn_en,
    input  logic              host_wr_en,
    input  logic [IDX_W-1:0]  host_wr_idx,
    input  logic              host_wr_vld,
    input  logic [TAG_W-1:0]  host_wr_tag,
    input  logic [HOP_W-1:0]  host_wr_hop,
    output logic              verdict_valid,
    output logic              verdict_drop,
    output logic [1:0]        verdict_cause
);

    logic [HOP_W-1:0] in_hop;
    logic             in_ttl_zero;
    hdr_stage_t       s1_q;
    hdr_stage_t       s2_q;
    tbl_entry_t       look_entry;
    cause_e           s2_cause;
    logic             learn_we;
    tbl_entry_t       learn_entry;
    logic             tbl_we;
    logic [IDX_W-1:0] tbl_widx;
    tbl_entry_t       tbl_wentry;
    logic             v_valid_q;
    logic             v_drop_q;
    cause_e           v_cause_q;

    hcf_hop_calc u_hop (
        .ttl      (hdr_ttl),
        .hop      (in_hop),
        .ttl_zero (in_ttl_zero)
    );

    // Stage 1: capture the header with its hop distance.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.vld      <= hdr_valid;
            s1_q.learn    <= learn_en;
            s1_q.ttl_zero <= in_ttl_zero;
            s1_q.idx      <= hdr_src_addr[IDX_W-1:0];
            s1_q.tag      <= hdr_src_addr[ADDR_W-1:IDX_W];
            s1_q.hop      <= in_hop;
        end
    end

    // Stage 2: the table read lands alongside this register.
    always_ff @(posedge clk) begin
        if (rst) s2_q <= '0;
        else     s2_q <= s1_q;
    end

    hcf_table u_tbl (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (s1_q.idx),
        .rd_entry (look_entry),
        .we       (tbl_we),
        .wr_idx   (tbl_widx),
        .wr_entry (tbl_wentry)
    );

    hcf_judge u_judge (
        .stg         (s2_q),
        .entry       (look_entry),
        .cause       (s2_cause),
        .learn_we    (learn_we),
        .learn_entry (learn_entry)
    );

    // Host port wins the single write port.
    always_comb begin
        tbl_we = host_wr_en || learn_we;
        if (host_wr_en) begin
            tbl_widx       = host_wr_idx;
            tbl_wentry.vld = host_wr_vld;
            tbl_wentry.tag = host_wr_tag;
            tbl_wentry.hop = host_wr_hop;
        end else begin
            tbl_widx   = s2_q.idx;
            tbl_wentry = learn_entry;
        end
    end

    // Stage 3: registered verdict.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_valid_q <= 1'b0;
            v_drop_q  <= 1'b0;
            v_cause_q <= CAUSE_HIT;
        end else begin
            v_valid_q <= s2_q.vld;
            if (s2_q.vld) begin
                v_cause_q <= s2_cause;
                v_drop_q  <= (s2_cause == CAUSE_HOP_BAD) || (s2_cause == CAUSE_TTL_ZERO);
            end else begin
                v_cause_q <= CAUSE_HIT;
                v_drop_q  <= 1'b0;
            end
        end
    end

    assign verdict_valid = v_valid_q;
    assign verdict_drop  = v_drop_q;
    assign verdict_cause = v_cause_q;

endmodule

// File: rtl/hcf_checker.sv
module hcf_checker
    import hcf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hdr_valid,
    input logic [TTL_W-1:0] hdr_ttl,
    input logic             learn_en,
    input logic             host_wr_en,
    input logic [IDX_W-1:0] host_wr_idx,
    input logic             verdict_valid,
    input logic             verdict_drop,
    input logic [1:0]       verdict_cause,
    input logic             tbl_we,
    input logic [IDX_W-1:0] tbl_widx
);

    // Edges seen since reset, saturating at 3, keeps $past inside live history.
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_HDR_GIVES_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && $past(hdr_valid, 3)) |-> verdict_valid); // R2

    AST_VERDICT_HAS_HDR: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> (since_rst == 2'd3 && $past(hdr_valid, 3))); // R2

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !verdict_valid |-> (verdict_cause == 2'd0 && !verdict_drop)); // R2

    AST_TTL_ZERO_DROP: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && $past(hdr_ttl, 3) == '0) |-> (verdict_cause == 2'd3 && verdict_drop)); // R5

    AST_HOST_WINS: assert property (@(posedge clk) disable iff (rst)
        host_wr_en |-> (tbl_we && tbl_widx == host_wr_idx)); // R10

    AST_LEARN_GATED: assert property (@(posedge clk) disable iff (rst)
        (tbl_we && !host_wr_en) |-> (since_rst >= 2'd2 && $past(hdr_valid, 2) && $past(learn_en, 2))); // R8

endmodule

bind hop_spoof_filter hcf_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .hdr_valid     (hdr_valid),
    .hdr_ttl       (hdr_ttl),
    .learn_en      (learn_en),
    .host_wr_en    (host_wr_en),
    .host_wr_idx   (host_wr_idx),
    .verdict_valid (verdict_valid),
    .verdict_drop  (verdict_drop),
    .verdict_cause (verdict_cause),
    .tbl_we        (tbl_we),
    .tbl_widx      (tbl_widx)
);

// File: tb/hop_spoof_filter_tb_top.sv
module hop_spoof_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_src_addr = '0;
    logic [7:0]  hdr_ttl = '0;
    logic        learn_en = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [9:0]  host_wr_idx = '0;
    logic        host_wr_vld = 1'b0;
    logic [21:0] host_wr_tag = '0;
    logic [4:0]  host_wr_hop = '0;
    logic        verdict_valid;
    logic        verdict_drop;
    logic [1:0]  verdict_cause;

    always #10 clk = ~clk;   // 50 MHz

    hop_spoof_filter dut_i (
        .clk           (clk),
        .rst           (rst),
        .hdr_valid     (hdr_valid),
        .hdr_src_addr  (hdr_src_addr),
        .hdr_ttl       (hdr_ttl),
        .learn_en      (learn_en),
        .host_wr_en    (host_wr_en),
        .host_wr_idx   (host_wr_idx),
        .host_wr_vld   (host_wr_vld),
        .host_wr_tag   (host_wr_tag),
        .host_wr_hop   (host_wr_hop),
        .verdict_valid (verdict_valid),
        .verdict_drop  (verdict_drop),
        .verdict_cause (verdict_cause)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 1'b0;

    // Reference table.
    bit          m_vld [1024];
    logic [21:0] m_tag [1024];
    logic [4:0]  m_hop [1024];

    int          q_cyc   [$];
    logic [1:0]  q_cause [$];
    string       q_req   [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_eq(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] ref_start(input logic [7:0] t);
        if (t <= 8'd30)       return 8'd30;
        else if (t <= 8'd32)  return 8'd32;
        else if (t <= 8'd60)  return 8'd60;
        else if (t <= 8'd64)  return 8'd64;
        else if (t <= 8'd128) return 8'd128;
        else                  return 8'd255;
    endfunction

    function automatic logic [4:0] ref_hop(input logic [7:0] t);
        logic [7:0] d;
        d = ref_start(t) - t;
        return (d > 8'd31) ? 5'd31 : d[4:0];
    endfunction

    // Sequential reference: headers take effect in arrival order.
    function automatic logic [1:0] model_step(input logic [31:0] src, input logic [7:0] t, input logic lrn);
        int idx;
        bit hit;
        idx = int'(src[9:0]);
        if (t == 8'd0) return 2'd3;
        hit = m_vld[idx] && (m_tag[idx] == src[31:10]);
        if (hit) return (m_hop[idx] == ref_hop(t)) ? 2'd0 : 2'd2;
        if (lrn) begin
            m_vld[idx] = 1'b1;
            m_tag[idx] = src[31:10];
            m_hop[idx] = ref_hop(t);
        end
        return 2'd1;
    endfunction

    task automatic send(input logic [31:0] src, input logic [7:0] t, input logic lrn, input string req);
        logic [1:0] e;
        @(negedge clk);
        host_wr_en   = 1'b0;
        hdr_valid    = 1'b1;
        hdr_src_addr = src;
        hdr_ttl      = t;
        learn_en     = lrn;
        e = model_step(src, t, lrn);
        q_cyc.push_back(cyc);
        q_cause.push_back(e);
        q_req.push_back(req);
    endtask

    task automatic pause();
        @(negedge clk);
        hdr_valid  = 1'b0;
        host_wr_en = 1'b0;
    endtask

    task automatic drain();
        pause();
        repeat (5) @(negedge clk);
    endtask

    task automatic hwrite(input int idx, input logic v, input logic [21:0] tag, input logic [4:0] hop);
        @(negedge clk);
        hdr_valid   = 1'b0;
        host_wr_en  = 1'b1;
        host_wr_idx = 10'(idx);
        host_wr_vld = v;
        host_wr_tag = tag;
        host_wr_hop = hop;
        m_vld[idx] = v;
        m_tag[idx] = tag;
        m_hop[idx] = hop;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    // Verdict monitor, sampling away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (verdict_valid) begin
                if (q_cyc.size() == 0) begin
                    check_eq("R2 unexpected verdict", 1, 0);
                end else begin
                    int         c;
                    logic [1:0] e;
                    string      r;
                    c = q_cyc.pop_front();
                    e = q_cause.pop_front();
                    r = q_req.pop_front();
                    check_eq("R2 latency", cyc - c, 3);
                    check_eq({r, " cause"}, int'(verdict_cause), int'(e));
                    check_eq({r, " drop"}, int'(verdict_drop), (e >= 2'd2) ? 1 : 0);
                end
            end else begin
                if (verdict_cause != 2'd0 || verdict_drop)
                    check_eq("R2 idle outputs", int'({verdict_drop, verdict_cause}), 0);
                if (q_cyc.size() > 0 && cyc > q_cyc[0] + 3) begin
                    check_eq("R2 missing verdict", 0, 1);
                    void'(q_cyc.pop_front());
                    void'(q_cause.pop_front());
                    void'(q_req.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [21:0] DTAG = 22'h15555;

    logic [31:0] pool [8] = '{32'hC0A8_0001, 32'h0A00_0401, 32'hAC10_2005, 32'h0808_0808,
                              32'h0101_0202, 32'h5DB8_0203, 32'h7F00_0002, 32'hDEAD_BEEF};
    logic [7:0]  base_ttl [8] = '{8'd52, 8'd117, 8'd240, 8'd60, 8'd30, 8'd64, 8'd128, 8'd255};

    // Directed TTL/hop pairs worked out from R3 and R4.
    logic [7:0] dir_ttl [15] = '{8'd1, 8'd30, 8'd31, 8'd32, 8'd33, 8'd60, 8'd61, 8'd64,
                                 8'd65, 8'd100, 8'd128, 8'd129, 8'd200, 8'd240, 8'd255};
    logic [4:0] dir_hop [15] = '{5'd29, 5'd0, 5'd1, 5'd0, 5'd27, 5'd0, 5'd3, 5'd0,
                                 5'd31, 5'd28, 5'd0, 5'd31, 5'd31, 5'd15, 5'd0};

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240517);
        for (int i = 0; i < 1024; i++) begin
            m_vld[i] = 1'b0;
            m_tag[i] = '0;
            m_hop[i] = '0;
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1 valid during reset", int'(verdict_valid), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1 valid after reset", int'(verdict_valid), 0);
        check_eq("R1 cause after reset", int'(verdict_cause), 0);

        // R1: empty table, first packet misses.
        send(32'h0102_0104, 8'd64, 1'b0, "R1");
        drain();

        // R3/R4: preload the exact hop, expect a match.
        for (int i = 0; i < 15; i++) begin
            hwrite(16'h140 + i, 1'b1, DTAG, dir_hop[i]);
            send({DTAG, 10'(16'h140 + i)}, dir_ttl[i], 1'b0, "R3_R4 boundary");
            drain();
        end
        // R6: stored hop off by one gives mismatch.
        hwrite(16'h160, 1'b1, DTAG, 5'd4);
        send({DTAG, 10'h160}, 8'd61, 1'b0, "R6 mismatch");
        send({DTAG, 10'h160}, 8'd60, 1'b0, "R6 mismatch");
        drain();

        // R5: TTL zero drops and never learns.
        send({DTAG, 10'h170}, 8'd0, 1'b1, "R5 ttl zero");
        drain();
        send({DTAG, 10'h170}, 8'd64, 1'b0, "R5 no write");
        send({DTAG, 10'h140}, 8'd0, 1'b0, "R5 ttl zero on hit");
        drain();

        // R7: learn on miss, next packet hits.
        send({DTAG, 10'h171}, 8'd50, 1'b1, "R7 learn miss");
        drain();
        send({DTAG, 10'h171}, 8'd50, 1'b0, "R7 learned hit");
        drain();

        // R8: learning off leaves the table untouched.
        send({DTAG, 10'h172}, 8'd50, 1'b0, "R8 miss");
        drain();
        send({DTAG, 10'h172}, 8'd50, 1'b0, "R8 still miss");
        drain();

        // R9: alias on index with different tag.
        send({22'h0ABCD, 10'h171}, 8'd50, 1'b0, "R9 tag alias");
        drain();

        // R10: host invalidation.
        hwrite(16'h171, 1'b0, DTAG, 5'd10);
        send({DTAG, 10'h171}, 8'd50, 1'b0, "R10 invalidated");
        drain();

        // R10: host write on the same cycle as a learn write, same index.
        send({DTAG, 10'h180}, 8'd60, 1'b1, "R10 collide learn");
        pause();
        @(negedge clk);
        host_wr_en  = 1'b1;
        host_wr_idx = 10'h180;
        host_wr_vld = 1'b1;
        host_wr_tag = DTAG;
        host_wr_hop = 5'd7;
        m_vld[10'h180] = 1'b1;
        m_tag[10'h180] = DTAG;
        m_hop[10'h180] = 5'd7;
        @(negedge clk);
        host_wr_en = 1'b0;
        drain();
        send({DTAG, 10'h180}, 8'd60, 1'b0, "R10 host wins");
        drain();

        // R10: colliding host write elsewhere discards the learn.
        send({DTAG, 10'h181}, 8'd60, 1'b1, "R10 collide other");
        pause();
        @(negedge clk);
        host_wr_en  = 1'b1;
        host_wr_idx = 10'h182;
        host_wr_vld = 1'b1;
        host_wr_tag = DTAG;
        host_wr_hop = 5'd3;
        m_vld[10'h181] = 1'b0;
        m_vld[10'h182] = 1'b1;
        m_tag[10'h182] = DTAG;
        m_hop[10'h182] = 5'd3;
        @(negedge clk);
        host_wr_en = 1'b0;
        drain();
        send({DTAG, 10'h181}, 8'd60, 1'b0, "R10 learn dropped");
        send({DTAG, 10'h182}, 8'd61, 1'b0, "R10 other written");
        drain();

        // R11: back-to-back from one new source.
        send({DTAG, 10'h190}, 8'd50, 1'b1, "R11 first");
        send({DTAG, 10'h190}, 8'd50, 1'b1, "R11 forwarded");
        send({DTAG, 10'h190}, 8'd49, 1'b1, "R11 two behind");
        drain();

        // Random mix over a small source pool with aliases.
        for (int k = 0; k < 600; k++) begin
            int unsigned p;
            logic [7:0]  t;
            p = $urandom % 8;
            t = base_ttl[p];
            if ($urandom % 4 == 0) t = 8'($urandom);
            if ($urandom % 25 == 0) t = 8'd0;
            if ($urandom % 4 == 0) pause();
            send(pool[p], t, ($urandom % 8) != 0, "R6_R7_R11 random");
        end
        drain();
        repeat (4) @(negedge clk);
        check_eq("R2 all verdicts returned", q_cyc.size(), 0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule